// File: doc/BRIEF.md
# Strobed quadrature sampling decoder

This block reads a two-phase quadrature encoder by sampling rather than by reacting to edges. While it runs, a timer counts whole microseconds, derived from the system clock, up to a programmable interval of 128 us times a power of two. At the end of each interval it compares the current phase pair with the pair it held at the previous sample. It then reports one signed motion sample: one step forward, one step back, no motion, or a distinct code when both phases moved between samples. Each new sample comes with a one-cycle ready pulse.

The encoder is assumed to be optical. For a programmable number of microseconds before each sample instant, the block drives an LED output active, and it releases the LED as soon as the sample is taken. The pin polarity is selectable. The phase inputs pass through a two-stage synchronizer. An optional debounce filter then rejects pulses shorter than a fixed number of clocks. A start strobe and a stop strobe frame the run, and a level enable gates it. Stopping a running decoder produces a one-cycle stopped pulse.

Top module: `strobed_quad_sampler`

## Requirements
- R1: After reset, sampleRdy, stoppedEvt and sampleVal are all zero and ledPin sits at its inactive level, which is the inverse of ledActiveHigh.
- R2: A start strobe takes effect only while enable is high, the decoder is idle and no stop strobe arrives in the same cycle. Accepting a start loads the current filtered phase pair as the reference and clears the microsecond count.
- R3: While running, sampleRdy pulses for one cycle every CLK_PER_US × BASE_US × 2^periodCode clock cycles. The count of microseconds is taken from a free-running divider.
- R4: A periodCode above MAX_CODE (10) gives the same interval as code 0.
- R5: The phase pair is written {A,B} and read along the forward cycle 00→01→11→10→00. One step forward gives sampleVal = +1 (3'b001), one step backward gives −1 (3'b111), and an unchanged pair gives 0 (3'b000).
- R6: A change of both phases between two samples gives sampleVal = 2 (3'b010). The reference pair is replaced by the new pair at every sample, whatever the code.
- R7: While running, the LED is active from the point where the remaining time in the interval is no more than ledLeadUs microseconds. It turns inactive in the same cycle that the new sample appears. A lead of 0 never lights the LED, and the LED is inactive while idle.
- R8: When ledActiveHigh = 1 the active level of ledPin is high. When ledActiveHigh = 0 the active level is low.
- R9: With debounceEn = 0 a phase level that the synchronizer holds at a sample instant is used as it is. With debounceEn = 1 a level must stay steady for DEB_LEN consecutive clocks before it is used, so a shorter pulse across a sample instant reads as no motion.
- R10: A stop strobe, or enable falling, while the decoder runs halts it, and stoppedEvt pulses once in the next cycle. A stop strobe while idle gives no pulse.
- R11: A stop that coincides with a sample instant cancels that sample: no sampleRdy accompanies the stoppedEvt pulse.
- R12: sampleVal holds its value between sample-ready pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startStrobe | input | 1 | One-cycle request to begin sampling |
| stopStrobe | input | 1 | One-cycle request to halt sampling |
| enable | input | 1 | Level gate; sampling needs it high |
| periodCode | input | 4 | Interval code, 128 us × 2^code |
| ledLeadUs | input | 8 | LED on-time before each sample, in microseconds |
| ledActiveHigh | input | 1 | 1: LED lit when pin high; 0: lit when pin low |
| debounceEn | input | 1 | Turns on the phase debounce filter |
| phaseA | input | 1 | Encoder phase A |
| phaseB | input | 1 | Encoder phase B |
| ledPin | output | 1 | LED drive |
| sampleVal | output | 3 | Signed motion sample: −1, 0, +1, or 2 for a double step |
| sampleRdy | output | 1 | One-cycle pulse when sampleVal is renewed |
| stoppedEvt | output | 1 | One-cycle pulse after a running decoder halts |

## Verification
A stop strobe can fall in exactly the cycle in which the interval ends. The bench provokes this by counting clocks from a sample-ready pulse to the next sample edge and driving the stop strobe so that it is sampled at that edge. The result is judged by a cycle-exact behavioural model and by a direct check: stoppedEvt must rise and sampleRdy must stay low. The same counting places a short phase glitch across a sample instant, once with debounce off and once with it on.

// File: rtl/sqd_pkg.sv
package sqd_pkg;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic load;     // start accepted: take current phases as reference
    logic capture;  // interval ended: decode and publish a sample
  } sqdStrobe_t;

  localparam int SMP_W = 3;

  localparam logic [SMP_W-1:0] SMP_NONE   = 3'b000;
  localparam logic [SMP_W-1:0] SMP_FWD    = 3'b001;
  localparam logic [SMP_W-1:0] SMP_BACK   = 3'b111;
  localparam logic [SMP_W-1:0] SMP_DOUBLE = 3'b010;

  // Position of a phase pair {A,B} along the forward Gray cycle.
  function automatic logic [1:0] grayPos(input logic [1:0] ab);
    return {ab[1], ab[1] ^ ab[0]};
  endfunction

endpackage

// File: rtl/sqd_line_filter.sv
module sqd_line_filter #(
  parameter int DEB_LEN = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  input  logic useFilter,
  output logic cleanOut
);

  localparam int CNT_W = $clog2(DEB_LEN + 1);

  logic syncA, syncB, heldLvl;
  logic [CNT_W-1:0] runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA   <= 1'b0;
      syncB   <= 1'b0;
      heldLvl <= 1'b0;
      runCnt  <= '0;
    end else begin
      syncA <= rawIn;
      syncB <= syncA;
      if (!useFilter || syncB == heldLvl) begin
        heldLvl <= syncB;
        runCnt  <= '0;
      end else if (runCnt == CNT_W'(DEB_LEN - 1)) begin
        heldLvl <= syncB;
        runCnt  <= '0;
      end else begin
        runCnt <= runCnt + CNT_W'(1);
      end
    end
  end

  assign cleanOut = useFilter ? heldLvl : syncB;

  // R9
  deb_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (useFilter && syncB == heldLvl) |=> (heldLvl == $past(heldLvl)));

endmodule

// File: rtl/sqd_datapath.sv
module sqd_datapath
  import sqd_pkg::*;
#(
  parameter int DEB_LEN = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             phaseA,
  input  logic             phaseB,
  input  logic             debounceEn,
  input  sqdStrobe_t       strb,
  output logic [SMP_W-1:0] sampleVal,
  output logic             sampleRdy
);

  localparam int LINES = 2;

  logic [LINES-1:0] rawAb, cleanAb;
  logic [1:0] prevAb, posDiff;
  logic [SMP_W-1:0] decoded;

  assign rawAb = {phaseA, phaseB};

  for (genvar i = 0; i < LINES; i++) begin : g_line
    sqd_line_filter #(.DEB_LEN(DEB_LEN)) u_filt (
      .clk      (clk),
      .rstN     (rstN),
      .rawIn    (rawAb[i]),
      .useFilter(debounceEn),
      .cleanOut (cleanAb[i])
    );
  end

  assign posDiff = grayPos(cleanAb) - grayPos(prevAb);

  always_comb begin
    unique case (posDiff)
      2'd0:    decoded = SMP_NONE;
      2'd1:    decoded = SMP_FWD;
      2'd3:    decoded = SMP_BACK;
      default: decoded = SMP_DOUBLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevAb    <= '0;
      sampleVal <= SMP_NONE;
      sampleRdy <= 1'b0;
    end else begin
      sampleRdy <= strb.capture;
      if (strb.load || strb.capture) prevAb <= cleanAb;
      if (strb.capture) sampleVal <= decoded;
    end
  end

  // R6
  rdy_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> sampleRdy);

  // R5
  legal_val_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleRdy |-> (sampleVal == SMP_NONE || sampleVal == SMP_FWD ||
                   sampleVal == SMP_BACK || sampleVal == SMP_DOUBLE));

  // R12
  val_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> $stable(sampleVal));

endmodule

// File: rtl/sqd_ctrl.sv
module sqd_ctrl
  import sqd_pkg::*;
#(
  parameter int CLK_PER_US = 50,
  parameter int BASE_US    = 128,
  parameter int MAX_CODE   = 10,
  parameter int CODE_W     = 4,
  parameter int LEAD_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startStrobe,
  input  logic              stopStrobe,
  input  logic              enable,
  input  logic [CODE_W-1:0] periodCode,
  input  logic [LEAD_W-1:0] ledLeadUs,
  input  logic              ledActiveHigh,
  output sqdStrobe_t        strb,
  output logic              ledPin,
  output logic              stoppedEvt
);

  localparam int UCNT_W = $clog2(BASE_US) + MAX_CODE + 1;
  localparam int DIV_W  = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;

  logic usTick;

  if (CLK_PER_US > 1) begin : g_div
    logic [DIV_W-1:0] divCnt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                  divCnt <= '0;
      else if (divCnt == DIV_W'(CLK_PER_US - 1))  divCnt <= '0;
      else                                        divCnt <= divCnt + DIV_W'(1);
    end
    assign usTick = (divCnt == DIV_W'(CLK_PER_US - 1));
  end else begin : g_nodiv
    assign usTick = 1'b1;
  end

  logic              running;
  logic [UCNT_W-1:0] usCnt, periodUs;
  logic [CODE_W-1:0] effCode;
  logic [UCNT_W:0]   leadSum;
  logic              lastUs, stopReq, startOk, captureNow, ledOn;

  assign effCode  = (periodCode > CODE_W'(MAX_CODE)) ? '0 : periodCode;
  assign periodUs = UCNT_W'(BASE_US) << effCode;
  assign lastUs   = (usCnt >= (periodUs - UCNT_W'(1)));

  assign stopReq    = stopStrobe | (running & ~enable);
  assign startOk    = startStrobe & enable & ~running & ~stopStrobe;
  assign captureNow = running & ~stopReq & usTick & lastUs;

  assign strb.load    = startOk;
  assign strb.capture = captureNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running    <= 1'b0;
      usCnt      <= '0;
      stoppedEvt <= 1'b0;
    end else begin
      stoppedEvt <= stopReq & running;
      if (stopReq) begin
        running <= 1'b0;
      end else if (startOk) begin
        running <= 1'b1;
        usCnt   <= '0;
      end else if (running && usTick) begin
        usCnt <= lastUs ? '0 : usCnt + UCNT_W'(1);
      end
    end
  end

  assign leadSum = {1'b0, usCnt} + (UCNT_W + 1)'(ledLeadUs);
  assign ledOn   = running && (ledLeadUs != '0) && (leadSum >= {1'b0, periodUs});
  assign ledPin  = ledOn ? ledActiveHigh : ~ledActiveHigh;

  // R3
  restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> (running && usCnt == '0));

  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(running) |-> $past(enable && startStrobe));

  // R10
  stopped_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    stoppedEvt |-> (!running && $past(running)));

endmodule

// File: rtl/strobed_quad_sampler.sv
module strobed_quad_sampler
  import sqd_pkg::*;
#(
  parameter int CLK_PER_US = 50,
  parameter int BASE_US    = 128,
  parameter int MAX_CODE   = 10,
  parameter int DEB_LEN    = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startStrobe,
  input  logic       stopStrobe,
  input  logic       enable,
  input  logic [3:0] periodCode,
  input  logic [7:0] ledLeadUs,
  input  logic       ledActiveHigh,
  input  logic       debounceEn,
  input  logic       phaseA,
  input  logic       phaseB,
  output logic       ledPin,
  output logic [2:0] sampleVal,
  output logic       sampleRdy,
  output logic       stoppedEvt
);

  sqdStrobe_t strb;

  sqd_ctrl #(
    .CLK_PER_US(CLK_PER_US),
    .BASE_US   (BASE_US),
    .MAX_CODE  (MAX_CODE),
    .CODE_W    (4),
    .LEAD_W    (8)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .startStrobe  (startStrobe),
    .stopStrobe   (stopStrobe),
    .enable       (enable),
    .periodCode   (periodCode),
    .ledLeadUs    (ledLeadUs),
    .ledActiveHigh(ledActiveHigh),
    .strb         (strb),
    .ledPin       (ledPin),
    .stoppedEvt   (stoppedEvt)
  );

  sqd_datapath #(.DEB_LEN(DEB_LEN)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .phaseA    (phaseA),
    .phaseB    (phaseB),
    .debounceEn(debounceEn),
    .strb      (strb),
    .sampleVal (sampleVal),
    .sampleRdy (sampleRdy)
  );

  // R11
  no_rdy_on_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    stoppedEvt |-> !sampleRdy);

endmodule

// File: tb/strobed_quad_sampler_test.sv
`timescale 1ns/1ps
module strobed_quad_sampler_test;

  localparam int CPU = 4;
  localparam int DEB = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startS = 0, stopS = 0, en = 0, pol = 0, deb = 0, pA = 0, pB = 0;
  logic [3:0] code = 0;
  logic [7:0] lead = 0;
  logic ledPin, sampleRdy, stoppedEvt;
  logic [2:0] sampleVal;

  always #10 clk = ~clk;  // 50 MHz

  strobed_quad_sampler #(.CLK_PER_US(CPU), .BASE_US(128), .MAX_CODE(10), .DEB_LEN(DEB)) uut (
    .clk(clk), .rstN(rstN), .startStrobe(startS), .stopStrobe(stopS), .enable(en),
    .periodCode(code), .ledLeadUs(lead), .ledActiveHigh(pol), .debounceEn(deb),
    .phaseA(pA), .phaseB(pB), .ledPin(ledPin), .sampleVal(sampleVal),
    .sampleRdy(sampleRdy), .stoppedEvt(stoppedEvt));

  int checks = 0, errors = 0;
  string curReq = "R1";

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int mDiv, mRun, mUcnt, mPrev, mVal, mRdy, mStop;
  int fm[2], runLen[2], h1[2], h2[2];
  longint cyc = 0;

  function automatic int periodOf(input int c);
    return 128 << ((c > 10) ? 0 : c);
  endfunction

  function automatic int expDelta(input int p, input int n);
    if (p == n) return 0;
    if ((p ^ n) == 3) return 2;
    if ((p == 0 && n == 1) || (p == 1 && n == 3) || (p == 3 && n == 2) || (p == 2 && n == 0))
      return 1;
    return 7;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rstN) begin
      mDiv = 0; mRun = 0; mUcnt = 0; mPrev = 0; mVal = 0; mRdy = 0; mStop = 0;
      for (int i = 0; i < 2; i++) begin fm[i] = 0; runLen[i] = 0; h1[i] = 0; h2[i] = 0; end
    end else begin
      int eff[2];
      int effAb, p;
      bit tick, stopReq;
      int rawNow[2];
      rawNow[1] = pA; rawNow[0] = pB;
      for (int i = 0; i < 2; i++) begin
        eff[i] = deb ? fm[i] : h2[i];
        if (!deb || h2[i] == fm[i]) begin fm[i] = h2[i]; runLen[i] = 0; end
        else if (runLen[i] == DEB - 1) begin fm[i] = h2[i]; runLen[i] = 0; end
        else runLen[i]++;
        h2[i] = h1[i]; h1[i] = rawNow[i];
      end
      effAb = eff[1] * 2 + eff[0];
      tick = (mDiv == CPU - 1);
      mDiv = tick ? 0 : mDiv + 1;
      p = periodOf(code);
      stopReq = stopS || (mRun != 0 && !en);
      mStop = (stopReq && mRun != 0) ? 1 : 0;
      mRdy = 0;
      if (stopReq) mRun = 0;
      else if (startS && en && mRun == 0) begin mRun = 1; mUcnt = 0; mPrev = effAb; end
      else if (mRun != 0 && tick) begin
        if (mUcnt >= p - 1) begin
          mUcnt = 0; mVal = expDelta(mPrev, effAb); mPrev = effAb; mRdy = 1;
        end else mUcnt++;
      end
    end
  end

  int rdySeen = 0, stopSeen = 0;
  always @(posedge clk) begin
    #5;
    if (rstN) begin
      int expLed;
      bit on;
      on = (mRun != 0) && (lead != 0) && (mUcnt + lead >= periodOf(code));
      expLed = on ? pol : !pol;
      chk(curReq, "sampleRdy", sampleRdy, mRdy);
      chk(curReq, "stoppedEvt", stoppedEvt, mStop);
      chk(curReq, "sampleVal", sampleVal, mVal);
      chk(curReq, "ledPin", ledPin, expLed);
      if (sampleRdy) rdySeen++;
      if (stoppedEvt) stopSeen++;
    end
  end

  // ---------------- stimulus helpers ----------------
  longint lastRdyCyc = 0, gap = 0;

  task automatic waitRdy();
    do @(negedge clk); while (!sampleRdy);
    gap = cyc - lastRdyCyc;
    lastRdyCyc = cyc;
  endtask

  task automatic pulseStart();
    startS = 1; @(negedge clk); startS = 0;
  endtask

  task automatic pulseStop();
    stopS = 1; @(negedge clk); stopS = 0;
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    summary();
    $finish;
  end

  localparam int T0 = 128 * CPU;

  initial begin
    int tgt[8] = '{1, 3, 2, 0, 0, 2, 3, 0};
    int expv[8] = '{1, 1, 1, 1, 0, 7, 7, 2};
    int base, held;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1", "sampleRdy", sampleRdy, 0);
    chk("R1", "stoppedEvt", stoppedEvt, 0);
    chk("R1", "sampleVal", sampleVal, 0);
    chk("R1", "ledPin", ledPin, 1);

    // Decoding along both directions plus a double step
    curReq = "R5"; en = 1; code = 0; lead = 10; pol = 1;
    pulseStart();
    waitRdy();
    chk("R5", "first sample with no motion", sampleVal, 0);
    for (int i = 0; i < 8; i++) begin
      repeat (100) @(negedge clk);
      {pA, pB} = 2'(tgt[i]);
      waitRdy();
      chk((i == 7) ? "R6" : "R5", "decoded step", sampleVal, expv[i]);
    end
    chk("R3", "interval at code 0", int'(gap), T0);

    // LED lead and release
    curReq = "R7";
    chk("R7", "LED released with sample", ledPin, 0);
    held = sampleVal;
    repeat (T0 - 6) @(negedge clk);
    chk("R7", "LED lit inside lead window", ledPin, 1);
    chk("R12", "value held between samples", sampleVal, held);

    curReq = "R8";
    waitRdy(); pol = 0;
    @(negedge clk);
    chk("R8", "inactive level when low-active", ledPin, 1);
    repeat (T0 - 8) @(negedge clk);
    chk("R8", "active level when low-active", ledPin, 0);

    curReq = "R7";
    waitRdy(); lead = 0;
    repeat (T0 - 3) @(negedge clk);
    chk("R7", "zero lead never lights", ledPin, 1);

    // Interval codes
    curReq = "R3";
    waitRdy(); code = 1;
    waitRdy();
    chk("R3", "interval at code 1", int'(gap), 2 * T0);
    curReq = "R4"; code = 13;
    waitRdy();
    chk("R4", "out-of-range code acts as 0", int'(gap), T0);
    code = 0; lead = 20; pol = 1;

    // Glitch across a sample instant, filter off then on
    curReq = "R9";
    waitRdy();
    repeat (T0 - 5) @(negedge clk);
    pA = 1;
    repeat (4) @(negedge clk);
    pA = 0;
    waitRdy();
    chk("R9", "glitch seen without filter", sampleVal, 7);
    waitRdy();
    chk("R9", "return step without filter", sampleVal, 1);
    deb = 1;
    repeat (T0 - 5) @(negedge clk);
    pA = 1;
    repeat (4) @(negedge clk);
    pA = 0;
    waitRdy();
    chk("R9", "glitch rejected by filter", sampleVal, 0);

    // Stop in the sample cycle
    curReq = "R11";
    waitRdy();
    base = rdySeen;
    repeat (T0 - 1) @(negedge clk);
    pulseStop();
    chk("R11", "stopped pulse at sample instant", stoppedEvt, 1);
    chk("R11", "sample cancelled", sampleRdy, 0);
    chk("R11", "no sample in stop cycle", rdySeen - base, 0);

    curReq = "R10";
    base = stopSeen;
    pulseStop();
    repeat (2) @(negedge clk);
    chk("R10", "no stopped pulse when idle", stopSeen - base, 0);

    // Start gating
    curReq = "R2";
    en = 0; base = rdySeen;
    pulseStart();
    repeat (3 * T0 / 2) @(negedge clk);
    chk("R2", "start ignored while disabled", rdySeen - base, 0);
    en = 1; startS = 1; stopS = 1;
    @(negedge clk);
    startS = 0; stopS = 0;
    repeat (3 * T0 / 2) @(negedge clk);
    chk("R2", "start with stop ignored", rdySeen - base, 0);

    // Enable falling while running
    curReq = "R10";
    pulseStart();
    waitRdy();
    chk("R2", "start accepted when enabled", sampleRdy, 1);
    en = 0;
    @(negedge clk);
    chk("R10", "stopped pulse on enable loss", stoppedEvt, 1);
    base = rdySeen;
    repeat (3 * T0 / 2) @(negedge clk);
    chk("R10", "halted after enable loss", rdySeen - base, 0);

    summary();
    $finish;
  end

endmodule